// File: doc/BRIEF.md
# Four-Channel Bus-Master Transfer Controller

This block moves bytes between memory and up to four peripherals without CPU involvement. While the CPU owns the bus, software programs each channel through an 8-bit register port. It loads a 16-bit start address and a 16-bit count word, then sets the channel enable bits. Peripherals raise a per-channel request. When an enabled channel with a legal transfer type has a request pending, the controller raises a hold request toward the CPU. It then waits for hold acknowledge before it touches the bus.

Once the bus is granted, the controller serves the pending channels one transfer at a time in fixed priority order. For each transfer it drives the memory address, the active-low acknowledge of the channel being served, and the active-low memory strobe that the channel's transfer type selects. A channel that completes its programmed block flags terminal count on its final transfer and switches itself off. Hold request is released as soon as no enabled channel is asking for service.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, hold request is low, all acknowledge outputs and both strobes are high (inactive), terminal count is low and every channel is disabled.
- R2: Register select values 2c and 2c+1 address channel c's start address and count word; select 8 is the mode register, whose bits 3:0 enable channels 0 to 3. A single shared byte pointer sends the first write of a 16-bit register to its low byte and the second to its high byte; reset and every mode-register write return the pointer to the low byte.
- R3: Hold request rises on the clock edge after an enabled channel with a legal type sees its request high. No acknowledge or strobe is driven before hold acknowledge (active high) has been seen.
- R4: When several eligible channels are pending, channel 0 is served first and channel 3 last; the choice is remade before every transfer.
- R5: A count field of N-1 in bits 13:0 of the count word yields exactly N transfers. The first transfer uses the programmed start address, and each later one uses the previous address plus one, wrapping modulo 2^16.
- R6: Terminal count is high only during a channel's final transfer, together with that channel's acknowledge. The channel is then disabled, and later requests from it raise no hold request.
- R7: Count word bits 15:14 select the type. 10 (memory to peripheral) pulls the memory read strobe low, 01 (peripheral to memory) pulls the memory write strobe low, and 00 (verify) asserts only the acknowledge with both strobes high.
- R8: A channel with type 11, or one not enabled, is never served, and its request alone leaves hold request low.
- R9: Register writes are ignored, and do not move the byte pointer, while hold request is high.
- R10: After the final pending transfer, hold request is low one clock after the cycle in which that transfer's acknowledge was visible.
- R11: At most one acknowledge output is low at any time, and the two memory strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | One-cycle register write strobe from the CPU |
| cpu_sel | input | 4 | Register select (channel registers 0 to 7, mode register 8) |
| cpu_wdata | input | 8 | Register write byte |
| dreq | input | 4 | Per-channel transfer request, active high |
| hlda | input | 1 | Hold acknowledge from the CPU, active high |
| hrq | output | 1 | Hold request to the CPU, active high |
| mem_addr | output | 16 | Memory address of the current transfer |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| tc | output | 1 | Terminal count, high during a channel's last transfer |

## Verification
The bench builds the controller with its defaults: four channels and an 8-bit data port, which gives 16-bit addresses and a 14-bit count field. Counts are kept to five transfers or fewer, so every channel reaches terminal count several times in a short run. Start addresses are drawn from the whole 16-bit range, and one directed case starts just below 0xFFFF to take the address through its wrap. Holding all four requests at once puts the priority order and the re-arbitration between transfers in view. The type-11 case, the hold-acknowledge delays and the writes made while the bus is held cover the ignored-stimulus requirements.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [1:0] {
    OP_VERIFY = 2'b00,
    OP_MEMWR  = 2'b01,
    OP_MEMRD  = 2'b10,
    OP_BAD    = 2'b11
  } dma_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_GRANT,
    ST_XFER
  } seq_st_e;

endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  parameter int CH_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cpu_we,
  input  logic [SEL_W-1:0]                 cpu_sel,
  input  logic [DATA_W-1:0]                cpu_wdata,
  input  logic                             slave_ok,
  input  logic                             xfer_done,
  input  logic [CH_W-1:0]                  xfer_ch,
  output logic [NUM_CH-1:0][2*DATA_W-1:0]  ch_addr,
  output logic [NUM_CH-1:0][1:0]           ch_op,
  output logic [NUM_CH-1:0]                ch_last,
  output logic [NUM_CH-1:0]                ch_ready
);

  localparam int REG_W    = 2 * DATA_W;
  localparam int CNT_W    = REG_W - 2;
  localparam int MODE_SEL = 2 * NUM_CH;

  logic [NUM_CH-1:0][REG_W-1:0] addr_q;
  logic [NUM_CH-1:0][REG_W-1:0] tcr_q;
  logic [NUM_CH-1:0]            en_q;
  logic                         ptr_q;

  logic            wr_ok, is_mode, is_chreg, is_tcr;
  logic [CH_W-1:0] sel_ch;
  logic            unused_mode_bits;

  assign wr_ok            = cpu_we & slave_ok;
  assign is_mode          = wr_ok && (cpu_sel == SEL_W'(MODE_SEL));
  assign is_chreg         = wr_ok && (cpu_sel < SEL_W'(MODE_SEL));
  assign is_tcr           = cpu_sel[0];
  assign sel_ch           = cpu_sel[CH_W:1];
  assign unused_mode_bits = ^cpu_wdata[DATA_W-1:NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= 1'b0;
      en_q   <= '0;
      addr_q <= '0;
      tcr_q  <= '0;
    end else begin
      if (is_mode) begin
        ptr_q <= 1'b0;
        en_q  <= cpu_wdata[NUM_CH-1:0];
      end else if (is_chreg) begin
        ptr_q <= ~ptr_q;
        if (!is_tcr) begin
          if (!ptr_q) addr_q[sel_ch][DATA_W-1:0]     <= cpu_wdata;
          else        addr_q[sel_ch][REG_W-1:DATA_W] <= cpu_wdata;
        end else begin
          if (!ptr_q) tcr_q[sel_ch][DATA_W-1:0]      <= cpu_wdata;
          else        tcr_q[sel_ch][REG_W-1:DATA_W]  <= cpu_wdata;
        end
      end
      if (xfer_done) begin
        addr_q[xfer_ch]             <= addr_q[xfer_ch] + 1'b1;
        tcr_q[xfer_ch][CNT_W-1:0]   <= tcr_q[xfer_ch][CNT_W-1:0] - 1'b1;
        if (tcr_q[xfer_ch][CNT_W-1:0] == '0) en_q[xfer_ch] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_addr[i]  = addr_q[i];
    assign ch_op[i]    = tcr_q[i][REG_W-1:REG_W-2];
    assign ch_last[i]  = (tcr_q[i][CNT_W-1:0] == '0);
    assign ch_ready[i] = en_q[i] && (dma_op_e'(tcr_q[i][REG_W-1:REG_W-2]) != OP_BAD);

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
      (xfer_done && xfer_ch == CH_W'(i)) |=> (addr_q[i] == $past(addr_q[i]) + 1'b1));

    p_self_disable_r6: assert property (@(posedge clk) disable iff (rst)
      (xfer_done && xfer_ch == CH_W'(i) && ch_last[i]) |=> !en_q[i]);

    p_slave_only_r9: assert property (@(posedge clk) disable iff (rst)
      (!slave_ok && !(xfer_done && xfer_ch == CH_W'(i))) |=>
        ($stable(addr_q[i]) && $stable(tcr_q[i])));
  end

  p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (!slave_ok) |=> $stable(ptr_q));

endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] gnt,
  output logic [CH_W-1:0]   gnt_idx,
  output logic              any
);

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      gnt[i] = req[i] & ~acc;
      acc    = acc | req[i];
    end
  end

  always_comb begin
    gnt_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (gnt[i]) gnt_idx = CH_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CH_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CH-1:0]               ready,
  input  logic [NUM_CH-1:0]               dreq,
  input  logic                            hlda,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]   ch_addr,
  input  logic [NUM_CH-1:0][1:0]          ch_op,
  input  logic [NUM_CH-1:0]               ch_last,
  output logic                            hrq,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic                            mem_rd_n,
  output logic                            mem_wr_n,
  output logic [NUM_CH-1:0]               dack_n,
  output logic                            tc,
  output logic                            xfer_done,
  output logic [CH_W-1:0]                 xfer_ch
);

  seq_st_e             st_q;
  logic [CH_W-1:0]     cur_q;
  logic                hrq_q, rd_n_q, wr_n_q, tc_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [NUM_CH-1:0]   dack_n_q;

  logic [NUM_CH-1:0]   pend, fin_mask, pend_eff, gnt;
  logic [CH_W-1:0]     gidx;
  logic                any_eff;
  dma_op_e             cur_op;

  assign pend   = ready & dreq;
  assign cur_op = dma_op_e'(ch_op[cur_q]);

  always_comb begin
    fin_mask = '0;
    if (st_q == ST_XFER && ch_last[cur_q]) fin_mask[cur_q] = 1'b1;
  end

  assign pend_eff = pend & ~fin_mask;

  dma4_prio #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_prio (
    .req     (pend_eff),
    .gnt     (gnt),
    .gnt_idx (gidx),
    .any     (any_eff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      hrq_q    <= 1'b0;
      addr_q   <= '0;
      rd_n_q   <= 1'b1;
      wr_n_q   <= 1'b1;
      dack_n_q <= '1;
      tc_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (any_eff) begin
            hrq_q <= 1'b1;
            st_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!any_eff) begin
            hrq_q <= 1'b0;
            st_q  <= ST_IDLE;
          end else if (hlda) begin
            cur_q <= gidx;
            st_q  <= ST_GRANT;
          end
        end
        ST_GRANT: begin
          addr_q   <= ch_addr[cur_q];
          dack_n_q <= ~(NUM_CH'(1) << cur_q);
          rd_n_q   <= (cur_op != OP_MEMRD);
          wr_n_q   <= (cur_op != OP_MEMWR);
          tc_q     <= ch_last[cur_q];
          st_q     <= ST_XFER;
        end
        default: begin
          dack_n_q <= '1;
          rd_n_q   <= 1'b1;
          wr_n_q   <= 1'b1;
          tc_q     <= 1'b0;
          if (any_eff && hlda) begin
            cur_q <= gidx;
            st_q  <= ST_GRANT;
          end else begin
            hrq_q <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign hrq       = hrq_q;
  assign mem_addr  = addr_q;
  assign mem_rd_n  = rd_n_q;
  assign mem_wr_n  = wr_n_q;
  assign dack_n    = dack_n_q;
  assign tc        = tc_q;
  assign xfer_done = (st_q == ST_XFER);
  assign xfer_ch   = cur_q;

  p_dack_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dack_n_q));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_q && !wr_n_q));

  p_strobe_needs_dack_r7: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_q || !wr_n_q) |-> (dack_n_q != '1));

  p_tc_with_dack_r6: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> (dack_n_q != '1));

  p_master_needs_hlda_r3: assert property (@(posedge clk) disable iff (rst)
    (dack_n_q != '1) |-> (hrq_q && $past(hlda, 2)));

  p_grant_prio_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GRANT) |-> $onehot(NUM_CH'(1) << cur_q) && ready[cur_q]);

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cpu_we,
  input  logic [$clog2(2*NUM_CH+1)-1:0]    cpu_sel,
  input  logic [DATA_W-1:0]                cpu_wdata,
  input  logic [NUM_CH-1:0]                dreq,
  input  logic                             hlda,
  output logic                             hrq,
  output logic [2*DATA_W-1:0]              mem_addr,
  output logic                             mem_rd_n,
  output logic                             mem_wr_n,
  output logic [NUM_CH-1:0]                dack_n,
  output logic                             tc
);

  localparam int SEL_W  = $clog2(2*NUM_CH+1);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int ADDR_W = 2 * DATA_W;

  logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
  logic [NUM_CH-1:0][1:0]        ch_op;
  logic [NUM_CH-1:0]             ch_last;
  logic [NUM_CH-1:0]             ch_ready;
  logic                          xfer_done;
  logic [CH_W-1:0]               xfer_ch;
  logic                          hrq_i;

  dma4_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .CH_W   (CH_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cpu_we    (cpu_we),
    .cpu_sel   (cpu_sel),
    .cpu_wdata (cpu_wdata),
    .slave_ok  (!hrq_i),
    .xfer_done (xfer_done),
    .xfer_ch   (xfer_ch),
    .ch_addr   (ch_addr),
    .ch_op     (ch_op),
    .ch_last   (ch_last),
    .ch_ready  (ch_ready)
  );

  dma4_seq #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CH_W   (CH_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ready     (ch_ready),
    .dreq      (dreq),
    .hlda      (hlda),
    .ch_addr   (ch_addr),
    .ch_op     (ch_op),
    .ch_last   (ch_last),
    .hrq       (hrq_i),
    .mem_addr  (mem_addr),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .dack_n    (dack_n),
    .tc        (tc),
    .xfer_done (xfer_done),
    .xfer_ch   (xfer_ch)
  );

  assign hrq = hrq_i;

endmodule

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXE       = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_sel = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [3:0]  dreq = '0;
  logic        hlda = 1'b0;
  logic        hrq, mem_rd_n, mem_wr_n, tc;
  logic [15:0] mem_addr;
  logic [3:0]  dack_n;

  int checks = 0;
  int fails  = 0;

  logic [15:0] p_addr [4];
  logic [1:0]  p_op   [4];
  logic [13:0] p_cnt  [4];

  int          exp_ch [MAXE];
  logic [15:0] exp_ad [MAXE];
  logic [1:0]  exp_op [MAXE];
  logic        exp_tc [MAXE];
  int          n_exp;

  dma4_ctrl uut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .dreq(dreq), .hlda(hlda), .hrq(hrq), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .dack_n(dack_n), .tc(tc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_rd_n(input logic [1:0] op);
    return !(op == 2'b10);
  endfunction

  function automatic logic exp_wr_n(input logic [1:0] op);
    return !(op == 2'b01);
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  task automatic wr(input logic [3:0] sel, input logic [7:0] data);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = data;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input logic [1:0] op, input logic [13:0] cnt);
    logic [15:0] w;
    w = {op, cnt};
    wr(4'(2*ch), a[7:0]);
    wr(4'(2*ch), a[15:8]);
    wr(4'(2*ch+1), w[7:0]);
    wr(4'(2*ch+1), w[15:8]);
    p_addr[ch] = a; p_op[ch] = op; p_cnt[ch] = cnt;
  endtask

  task automatic build(input logic [3:0] en);
    n_exp = 0;
    for (int c = 0; c < 4; c++) begin
      if (en[c] && p_op[c] != 2'b11) begin
        for (int k = 0; k <= int'(p_cnt[c]); k++) begin
          exp_ch[n_exp] = c;
          exp_ad[n_exp] = p_addr[c] + 16'(k);
          exp_op[n_exp] = p_op[c];
          exp_tc[n_exp] = (k == int'(p_cnt[c]));
          n_exp++;
        end
      end
    end
  endtask

  task automatic run_burst(input logic [3:0] en, input int dly, input bit poke);
    int idx;
    bit done;
    int ch;
    build(en);
    wr(4'd8, {4'b0, en});
    dreq = en;
    @(negedge clk);
    if (n_exp == 0) begin
      repeat (6) @(negedge clk);
      chk("R8 ineligible request keeps hold request low", hrq, 1'b0);
      dreq = '0;
      return;
    end
    chk("R3 hold request raised", hrq, 1'b1);
    if (poke) begin
      wr(4'd0, 8'hAA);
      wr(4'd0, 8'hBB);
    end
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk("R3 no acknowledge before hold acknowledge", dack_n, 4'hF);
    end
    chk("R3 no strobe before hold acknowledge", {mem_rd_n, mem_wr_n}, 2'b11);
    hlda = 1'b1;
    idx = 0;
    done = 1'b0;
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk);
      if (dack_n != 4'hF) begin
        ch = 0;
        for (int c = 0; c < 4; c++) if (!dack_n[c]) ch = c;
        chk("R11 single acknowledge", $countones(~dack_n), 1);
        if (idx >= n_exp) begin
          chk("R5 no extra transfer", idx, n_exp - 1);
        end else begin
          chk("R4 channel order", ch, exp_ch[idx]);
          chk("R5 transfer address", mem_addr, exp_ad[idx]);
          chk("R7 read strobe", mem_rd_n, exp_rd_n(exp_op[idx]));
          chk("R7 write strobe", mem_wr_n, exp_wr_n(exp_op[idx]));
          chk("R6 terminal count", tc, exp_tc[idx]);
        end
        if (tc) dreq[ch] = 1'b0;
        idx++;
        if (idx == n_exp) begin
          @(negedge clk);
          chk("R10 hold request released", hrq, 1'b0);
          done = 1'b1;
        end
      end else if (tc) begin
        chk("R6 terminal count only with acknowledge", tc, 1'b0);
      end
    end
    chk("R5 transfer count", idx, n_exp);
    hlda = 1'b0;
    @(negedge clk);
    dreq = en;
    repeat (4) @(negedge clk);
    chk("R6 finished channels stay disabled", hrq, 1'b0);
    dreq = '0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin p_addr[c] = '0; p_op[c] = '0; p_cnt[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 hold request after reset", hrq, 1'b0);
    chk("R1 acknowledges after reset", dack_n, 4'hF);
    chk("R1 strobes after reset", {mem_rd_n, mem_wr_n}, 2'b11);
    chk("R1 terminal count after reset", tc, 1'b0);
    dreq = 4'hF;
    repeat (3) @(negedge clk);
    chk("R1 channels disabled after reset", hrq, 1'b0);
    dreq = '0;

    // R2: mode write returns byte pointer to the low byte
    wr(4'd8, 8'h00);
    wr(4'd0, 8'h55);
    wr(4'd8, 8'h00);
    prog(0, 16'h1234, 2'b10, 14'd0);
    run_burst(4'b0001, 1, 1'b0);

    // R8: type 11 never served
    prog(1, 16'h4000, 2'b11, 14'd2);
    run_burst(4'b0010, 0, 1'b0);

    // R9: writes while the bus is requested are ignored
    prog(0, 16'h0100, 2'b10, 14'd1);
    run_burst(4'b0001, 3, 1'b1);

    // R5 / R7: verify type across the address wrap
    prog(3, 16'hFFFE, 2'b00, 14'd3);
    run_burst(4'b1000, 0, 1'b0);

    // R4: all channels pending together
    prog(0, 16'h1000, 2'b01, 14'd1);
    prog(1, 16'h2000, 2'b10, 14'd2);
    prog(2, 16'h3000, 2'b00, 14'd0);
    prog(3, 16'h4000, 2'b01, 14'd1);
    run_burst(4'b1111, 2, 1'b0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      for (int c = 0; c < 4; c++)
        prog(c, 16'($urandom), 2'($urandom % 4), 14'($urandom % 5));
      run_burst(4'($urandom % 16), int'($urandom % 4), 1'b0);
    end

    report();
    $finish;
  end

endmodule